// File: doc/BRIEF.md
# Chained FIFO Depth-Expansion Token Controller

This block is the per-device control that lets several FIFO devices be chained into one deeper buffer. Only one device in the chain accepts writes at a time, and only one delivers reads at a time. That right is a token. When a device writes into its last memory location, it sends a one-cycle pulse to the next device, which then takes over writing. Reads pass along the chain the same way, each device handing on when it reads its last location. The outputs `wr_allow` and `rd_allow` tell the local memory whether it may take the current strobe. The memory itself and its pointers live outside the block: the block is only told whether the current access is at the last location.

The strap `lead_n` is tied low on the device that starts the chain and high on all the others. The expansion inputs of each device are driven by the expansion outputs of the device before it. The last device feeds the first one, which closes the ring.

In single-device mode (`solo_mode` high) there is no chain. The device keeps both rights at all times, and the read expansion output stays low. The write expansion output is reused as a half-full indicator, worked out from a local count of accepted writes and reads.

Both sides run on one clock, `clk`, with a synchronous active-high reset.

Top module: `chainexp_ctrl`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `wr_allow` and `rd_allow` are both 1 when `solo_mode` is 1 or `lead_n` is 0, and both 0 otherwise. `wr_xout_hf` and `rd_xout` are 0 after reset when no more than half the depth is filled.
- R2: In chain mode (`solo_mode` = 0), an accepted write at the last location (`wr_req`, `wr_allow` and `wr_at_last` all 1 at an edge) drives `wr_xout_hf` to 1 for exactly the one following cycle.
- R3: In chain mode, an accepted read at the last location (`rd_req`, `rd_allow` and `rd_at_last` all 1 at an edge) drives `rd_xout` to 1 for exactly the one following cycle.
- R4: In the same cycle that an expansion pulse is visible, the matching allow output is 0, unless an expansion input pulse arrived at the same edge.
- R5: In chain mode, a 1 on `wr_xin` or `rd_xin` at an edge makes `wr_allow` or `rd_allow` respectively 1 from the next cycle on.
- R6: A strobe that is not at the last location, or a strobe made while the matching allow is 0, produces no expansion pulse and leaves the allow output unchanged.
- R7: In solo mode, `wr_allow` and `rd_allow` stay 1 and `rd_xout` stays 0, whatever `wr_at_last` and `rd_at_last` are.
- R8: In solo mode, `wr_xout_hf` is 1 exactly when accepted writes minus accepted reads exceeds DEPTH/2. It is updated in the cycle after the access. The count does not go below 0 or above DEPTH.
- R9: If a release and an expansion input pulse fall on the same edge, the device keeps its right.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| solo_mode | input | 1 | Strap: 1 selects single-device mode |
| lead_n | input | 1 | Strap: 0 on the device that starts the chain |
| wr_req | input | 1 | Local write strobe |
| wr_at_last | input | 1 | Write pointer is at the last location |
| wr_xin | input | 1 | Write hand-over pulse from the previous device |
| rd_req | input | 1 | Local read strobe |
| rd_at_last | input | 1 | Read pointer is at the last location |
| rd_xin | input | 1 | Read hand-over pulse from the previous device |
| wr_allow | output | 1 | Local memory may accept a write |
| rd_allow | output | 1 | Local memory may deliver a read |
| wr_xout_hf | output | 1 | Write hand-over pulse in chain mode; half-full in solo mode |
| rd_xout | output | 1 | Read hand-over pulse to the next device |

## Verification
A table of chain-mode patterns drives the device through its life in the ring:
- a plain write, which must leave the token in place;
- a last-location write, which must emit a pulse and drop the token;
- a last-location write with no token, which must be ignored;
- an incoming pulse, which must restore the token;
- an incoming pulse together with a release, which must keep the token.

These patterns separate a pulse that lasts too long, a token that is never released, and a token that is lost on a coincident hand-over.

Directed tests then cover reset on a device that does not start the chain. They also cover solo mode:
- last-location strobes, which must be ignored;
- the half-full threshold crossed in both directions;
- reads on an empty count, which show that the count saturates at zero instead of wrapping.

// File: rtl/chainexp_pkg.sv
package chainexp_pkg;

    // Number of token sides: index 0 is write, index 1 is read
    localparam int SIDES = 2;

    // Per-side stimulus seen by one token engine
    typedef struct packed {
        logic req;
        logic at_last;
        logic xin;
    } side_in_t;

    // Per-side registered state
    typedef struct packed {
        logic token;
        logic pulse;
    } side_st_t;

    // An incoming hand-over wins over a release on the same edge
    function automatic logic token_next(logic held, logic give_up, logic gain);
        return (held & ~give_up) | gain;
    endfunction

    // Which devices own both tokens coming out of reset
    function automatic logic owns_at_reset(logic lead_n, logic solo);
        return solo | ~lead_n;
    endfunction

endpackage

// File: rtl/chainexp_token.sv
module chainexp_token
    import chainexp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     solo,
    input  logic     lead_n,
    input  side_in_t sin,
    output side_st_t st
);

    logic fire;

    // Release happens on an accepted access at the last location
    assign fire = sin.req & st.token & sin.at_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            st.token <= owns_at_reset(lead_n, solo);
            st.pulse <= 1'b0;
        end else if (solo) begin
            st.token <= 1'b1;
            st.pulse <= 1'b0;
        end else begin
            st.pulse <= fire;
            st.token <= token_next(st.token, fire, sin.xin);
        end
    end

endmodule

// File: rtl/chainexp_fill.sv
module chainexp_fill #(
    parameter int DEPTH = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic wr_do,
    input  logic rd_do,
    output logic half
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            unique case ({wr_do, rd_do})
                2'b10:   if (count != FULL_CNT) count <= count + 1'b1;
                2'b01:   if (count != '0)       count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign half = (count > HALF_CNT);

endmodule

// File: rtl/chainexp_ctrl.sv
module chainexp_ctrl
    import chainexp_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic clk,
    input  logic rst,
    input  logic solo_mode,
    input  logic lead_n,
    input  logic wr_req,
    input  logic wr_at_last,
    input  logic wr_xin,
    input  logic rd_req,
    input  logic rd_at_last,
    input  logic rd_xin,
    output logic wr_allow,
    output logic rd_allow,
    output logic wr_xout_hf,
    output logic rd_xout
);

    side_in_t sin [SIDES];
    side_st_t st  [SIDES];
    logic     half;

    assign sin[0] = '{req: wr_req, at_last: wr_at_last, xin: wr_xin};
    assign sin[1] = '{req: rd_req, at_last: rd_at_last, xin: rd_xin};

    for (genvar g = 0; g < SIDES; g++) begin : g_side
        chainexp_token u_tok (
            .clk    (clk),
            .rst    (rst),
            .solo   (solo_mode),
            .lead_n (lead_n),
            .sin    (sin[g]),
            .st     (st[g])
        );
    end

    assign wr_allow = st[0].token;
    assign rd_allow = st[1].token;

    chainexp_fill #(.DEPTH(DEPTH)) u_fill (
        .clk   (clk),
        .rst   (rst),
        .wr_do (wr_req & wr_allow),
        .rd_do (rd_req & rd_allow),
        .half  (half)
    );

    // The shared pin carries half-full in solo mode, the write hand-over otherwise
    assign wr_xout_hf = solo_mode ? half : st[0].pulse;
    assign rd_xout    = st[1].pulse;

endmodule

// File: rtl/chainexp_checker.sv
module chainexp_checker (
    input logic clk,
    input logic rst,
    input logic solo_mode,
    input logic lead_n,
    input logic wr_req,
    input logic wr_at_last,
    input logic wr_xin,
    input logic rd_req,
    input logic rd_at_last,
    input logic rd_xin,
    input logic wr_allow,
    input logic rd_allow,
    input logic wr_xout_hf,
    input logic rd_xout
);

    // R1
    reset_owner_chk: assert property (@(posedge clk)
        rst |=> (wr_allow == $past(solo_mode | ~lead_n)) && (rd_allow == wr_allow));

    // R3
    rd_pulse_cause_chk: assert property (@(posedge clk) disable iff (rst)
        rd_xout |-> $past(rd_req & rd_allow & rd_at_last));

    // R3
    rd_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        rd_xout |=> !rd_xout);

    // R2
    wr_pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        (!solo_mode && wr_xout_hf) |=> !wr_xout_hf);

    // R4
    wr_release_chk: assert property (@(posedge clk) disable iff (rst)
        (!solo_mode && wr_xout_hf && !$past(wr_xin)) |-> !wr_allow);

    // R5
    rd_gain_chk: assert property (@(posedge clk) disable iff (rst)
        (!solo_mode && rd_xin) |=> rd_allow);

    // R7
    solo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        solo_mode |-> (wr_allow && rd_allow && !rd_xout));

    // R8
    half_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (solo_mode && !(wr_req && wr_allow) && !(rd_req && rd_allow)) |=> $stable(wr_xout_hf));

endmodule

bind chainexp_ctrl chainexp_checker u_chk (.*);

// File: tb/chainexp_ctrl_tb.sv
`timescale 1ns/1ps
module chainexp_ctrl_tb;

    localparam int DEPTH = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic solo_mode = 1'b0, lead_n = 1'b0;
    logic wr_req = 1'b0, wr_at_last = 1'b0, wr_xin = 1'b0;
    logic rd_req = 1'b0, rd_at_last = 1'b0, rd_xin = 1'b0;
    logic wr_allow, rd_allow, wr_xout_hf, rd_xout;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    chainexp_ctrl #(.DEPTH(DEPTH)) u_dut (.*);

    // Vector: {wr_req, wr_at_last, wr_xin, rd_req, rd_at_last, rd_xin,
    //          exp wr_allow, exp rd_allow, exp wr_xout_hf, exp rd_xout}
    // Chain mode, device starting the chain; expectations are after the edge.
    localparam int NV = 11;
    localparam logic [9:0] VEC [NV] = '{
        10'b000000_1100,  // idle, both tokens held (R1)
        10'b100000_1100,  // write not at last: no pulse (R6)
        10'b110000_0110,  // last write: pulse, token dropped (R2, R4)
        10'b000000_0100,  // pulse gone after one cycle (R2)
        10'b110000_0100,  // last write without token: ignored (R6)
        10'b001000_1100,  // write hand-over in (R5)
        10'b000110_1001,  // last read: pulse, token dropped (R3, R4)
        10'b000000_1000,  // read pulse one cycle (R3)
        10'b000111_1100,  // read hand-over in; read without token ignored (R5, R6)
        10'b111000_1110,  // release and hand-over on same edge (R9)
        10'b000000_1100   // idle after coincident hand-over (R9)
    };

    task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %b expected %b", tag, act, exp);
        end
    endtask

    task automatic do_reset(input logic lead, input logic solo);
        rst = 1'b1;
        lead_n = lead;
        solo_mode = solo;
        {wr_req, wr_at_last, wr_xin, rd_req, rd_at_last, rd_xin} = '0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic apply(input logic [5:0] v);
        {wr_req, wr_at_last, wr_xin, rd_req, rd_at_last, rd_xin} = v;
        @(negedge clk);
    endtask

    function automatic logic [3:0] outs();
        return {wr_allow, rd_allow, wr_xout_hf, rd_xout};
    endfunction

    initial begin
        #(200000 * 5);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R1: first device of the chain holds both tokens
        do_reset(1'b0, 1'b0);
        chk("R1 reset first device", outs(), 4'b1100);

        for (int i = 0; i < NV; i++) begin
            apply(VEC[i][9:4]);
            chk($sformatf("R2..R9 vector %0d", i), outs(), VEC[i][3:0]);
        end

        // R1: a device that does not start the chain holds nothing
        do_reset(1'b1, 1'b0);
        chk("R1 reset other device", outs(), 4'b0000);
        apply(6'b000001);
        chk("R5 read token gained", outs(), 4'b0100);
        apply(6'b001000);
        chk("R5 write token gained", outs(), 4'b1100);

        // R7: solo mode holds both rights; last-location strobes are ignored
        do_reset(1'b1, 1'b1);
        chk("R1 reset solo", outs(), 4'b1100);
        apply(6'b000110);
        chk("R7 solo last read", outs(), 4'b1100);
        apply(6'b000110);  // count back to 0 (saturated)
        // R8: half-full after DEPTH/2 + 1 accepted writes
        for (int k = 1; k <= DEPTH / 2; k++) apply(6'b110000);
        chk("R8 exactly half", outs(), 4'b1100);
        apply(6'b100000);
        chk("R8 above half", outs(), 4'b1110);
        apply(6'b110110);
        chk("R8 write and read together", outs(), 4'b1110);
        apply(6'b000100);
        chk("R8 back to half", outs(), 4'b1100);

        // R8: reads on an empty count do not wrap
        do_reset(1'b0, 1'b1);
        for (int k = 0; k < 3; k++) apply(6'b000100);
        chk("R8 empty reads", outs(), 4'b1100);
        for (int k = 1; k <= DEPTH / 2; k++) apply(6'b100000);
        chk("R8 half after empty reads", outs(), 4'b1100);
        apply(6'b100000);
        chk("R8 above half after empty reads", outs(), 4'b1110);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule